// File: doc/BRIEF.md
# SDRAM Column Address Multiplexer

This block places the column portion of a physical byte address onto the twelve DRAM address pins when a read or write column command is issued. The memory data bus is eight bytes wide, so the three lowest address bits select a byte inside a beat and never reach the pins. A 3-bit page-size selector sets how many column bits are in use, from 7 (1 KiB page) up to 11 (16 KiB page). The page size in bytes is two raised to the column-bit count plus three.

The auto-precharge request always sits on its dedicated pin, address pin 10. For the widest page the eleventh column bit cannot use that pin, so it moves up to pin 11. Pins above the highest column bit in use, other than pin 10, are driven low. Selector values 5, 6 and 7 mean the page size is unsupported. A command that carries one of these values produces no column command and raises an error flag. The address bus, the command strobe and the error flag are all registered. They change one clock after a strobe and keep their values between strobes.

Top module: `col_addr_mux`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, mem_addr is 0, col_cmd is 0 and cfg_err is 0.
- R2: phys_addr bits 2..0 have no effect on mem_addr.
- R3: For page codes 0, 1 and 2 (7, 8 and 9 column bits, n = 7 + code), mem_addr[n-1:0] equals phys_addr[n+2:3]. All pins above n-1 except pin 10 are 0.
- R4: For page code 3 (10 column bits), mem_addr[9:0] equals phys_addr[12:3] and mem_addr[11] is 0.
- R5: For page code 4 (11 column bits), mem_addr[9:0] equals phys_addr[12:3] and mem_addr[11] equals phys_addr[13].
- R6: For every supported page code (0 to 4), mem_addr[10] equals auto_pre.
- R7: Outputs update only on the clock edge at which cmd_valid is 1. In a cycle without cmd_valid, mem_addr and cfg_err keep their values.
- R8: A strobe with page code 5, 6 or 7 sets cfg_err to 1, leaves col_cmd at 0 and leaves mem_addr unchanged.
- R9: A strobe with a supported page code pulses col_cmd high for exactly the following cycle and clears cfg_err. With no strobe, col_cmd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Column command strobe |
| page_code | input | 3 | Page-size selector (0 to 4 supported; 5 to 7 unsupported) |
| phys_addr | input | 14 | Physical column byte address |
| auto_pre | input | 1 | Auto-precharge request |
| mem_addr | output | 12 | Registered DRAM address pins |
| col_cmd | output | 1 | Registered column command issued |
| cfg_err | output | 1 | Registered unsupported page-size flag |

## Verification
Each of the eight page codes is driven with random addresses and a random auto-precharge bit. This separates an off-by-one shift or a wrong column-bit count from a correct mapping. Addresses that are all ones and addresses with one bit set make it visible when pin 11 or pin 10 is driven at the wrong code. Two strobes that differ only in the three byte-offset bits must give the same bus, which exposes any leak of those bits. Cycles with the strobe low are interleaved with strobes to show holding behaviour. Unsupported codes are placed between supported ones to show both setting and clearing of the error flag.

// File: rtl/col_mux_pkg.sv
package col_mux_pkg;
   localparam int BYTE_OFS  = 3;
   localparam int MIN_COLS  = 7;
   localparam int MAX_CODE  = 4;
   localparam int MAX_COLS  = MIN_COLS + MAX_CODE;
   localparam int PA_W      = BYTE_OFS + MAX_COLS;
   localparam int MA_W      = MAX_COLS + 1;
   localparam int AP_PIN    = 10;
   localparam int CODE_W    = 3;

   typedef logic [CODE_W-1:0] page_code_t;
   typedef logic [MA_W-1:0]   mem_addr_t;
endpackage

// File: rtl/col_code_decode.sv
module col_code_decode #(
   parameter int CODE_W   = col_mux_pkg::CODE_W,
   parameter int MIN_COLS = col_mux_pkg::MIN_COLS,
   parameter int MAX_CODE = col_mux_pkg::MAX_CODE,
   localparam int MAX_COLS = MIN_COLS + MAX_CODE
) (
   input  logic [CODE_W-1:0]   code,
   output logic                code_ok,
   output logic [MAX_COLS-1:0] col_en
);
   initial begin
      if (MAX_CODE >= (1 << CODE_W))
         $error("MAX_CODE does not fit in CODE_W bits");
   end

   assign code_ok = (int'(code) <= MAX_CODE);

   for (genvar j = 0; j < MAX_COLS; j++) begin : g_en
      if (j < MIN_COLS) begin : g_always
         assign col_en[j] = code_ok;
      end else begin : g_coded
         assign col_en[j] = code_ok && (int'(code) > (j - MIN_COLS));
      end
   end
endmodule

// File: rtl/col_bit_map.sv
module col_bit_map #(
   parameter int MAX_COLS = col_mux_pkg::MAX_COLS,
   parameter int AP_PIN   = col_mux_pkg::AP_PIN,
   localparam int MA_W    = MAX_COLS + 1
) (
   input  logic [MAX_COLS-1:0] col_bits,
   input  logic [MAX_COLS-1:0] col_en,
   input  logic                auto_pre,
   output logic [MA_W-1:0]     pins
);
   initial begin
      if (AP_PIN >= MA_W || AP_PIN < 1)
         $error("AP_PIN outside address bus");
   end

   for (genvar p = 0; p < MA_W; p++) begin : g_pin
      if (p == AP_PIN) begin : g_ap
         assign pins[p] = auto_pre;
      end else begin : g_col
         localparam int J = (p < AP_PIN) ? p : p - 1;
         assign pins[p] = col_en[J] & col_bits[J];
      end
   end
endmodule

// File: rtl/col_addr_mux.sv
module col_addr_mux #(
   parameter int BYTE_OFS = col_mux_pkg::BYTE_OFS,
   parameter int MIN_COLS = col_mux_pkg::MIN_COLS,
   parameter int MAX_CODE = col_mux_pkg::MAX_CODE,
   parameter int AP_PIN   = col_mux_pkg::AP_PIN,
   parameter int CODE_W   = col_mux_pkg::CODE_W,
   localparam int MAX_COLS = MIN_COLS + MAX_CODE,
   localparam int PA_W     = BYTE_OFS + MAX_COLS,
   localparam int MA_W     = MAX_COLS + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [CODE_W-1:0] page_code,
   input  logic [PA_W-1:0]   phys_addr,
   input  logic              auto_pre,
   output logic [MA_W-1:0]   mem_addr,
   output logic              col_cmd,
   output logic              cfg_err
);
   initial begin
      if (BYTE_OFS < 1) $error("BYTE_OFS must be at least 1");
      if (MIN_COLS < 1) $error("MIN_COLS must be at least 1");
   end

   logic                code_ok;
   logic [MAX_COLS-1:0] col_en;
   logic [MA_W-1:0]     next_pins;
   logic                unused_byte_lanes;

   assign unused_byte_lanes = ^phys_addr[BYTE_OFS-1:0];

   col_code_decode #(
      .CODE_W(CODE_W), .MIN_COLS(MIN_COLS), .MAX_CODE(MAX_CODE)
   ) u_dec (
      .code(page_code), .code_ok(code_ok), .col_en(col_en)
   );

   col_bit_map #(
      .MAX_COLS(MAX_COLS), .AP_PIN(AP_PIN)
   ) u_map (
      .col_bits(phys_addr[PA_W-1:BYTE_OFS]),
      .col_en(col_en),
      .auto_pre(auto_pre),
      .pins(next_pins)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         col_cmd  <= 1'b0;
         cfg_err  <= 1'b0;
      end else begin
         col_cmd <= cmd_valid && code_ok;
         if (cmd_valid) begin
            cfg_err <= !code_ok;
            if (code_ok) mem_addr <= next_pins;
         end
      end
   end

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(mem_addr) && $stable(cfg_err)));

   assert_bad_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && int'(page_code) > MAX_CODE) |=>
         (cfg_err && !col_cmd && $stable(mem_addr)));

   assert_ap_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && int'(page_code) <= MAX_CODE) |=>
         (mem_addr[AP_PIN] == $past(auto_pre)));

   assert_cmd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && int'(page_code) <= MAX_CODE) |=> (col_cmd && !cfg_err));

   assert_no_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !col_cmd);
endmodule

// File: tb/col_addr_mux_tb.sv
module col_addr_mux_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  page_code = '0;
   logic [13:0] phys_addr = '0;
   logic        auto_pre = 1'b0;
   logic [11:0] mem_addr;
   logic        col_cmd, cfg_err;

   int checks = 0, fails = 0;
   logic [11:0] e_ma = '0;
   logic        e_err = 1'b0, e_cmd = 1'b0;
   bit          done = 0;

   always #10 clk = ~clk;

   col_addr_mux u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .page_code(page_code),
      .phys_addr(phys_addr), .auto_pre(auto_pre), .mem_addr(mem_addr),
      .col_cmd(col_cmd), .cfg_err(cfg_err)
   );

   function automatic logic [11:0] map_pins(input logic [2:0] c,
                                            input logic [13:0] pa,
                                            input logic ap);
      logic [11:0] r = '0;
      int n = 7 + int'(c);
      for (int j = 0; j < n; j++) begin
         if (j < 10) r[j] = pa[j+3];
         else        r[11] = pa[j+3];
      end
      r[10] = ap;
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input logic v, input logic [2:0] c,
                        input logic [13:0] pa, input logic ap);
      string tag;
      cmd_valid = v; page_code = c; phys_addr = pa; auto_pre = ap;
      @(posedge clk);
      @(negedge clk);
      e_cmd = v && (c <= 4);
      if (v) begin
         e_err = (c > 4);
         if (c <= 4) e_ma = map_pins(c, pa, ap);
      end
      if (!v)          tag = "R7";
      else if (c > 4)  tag = "R8";
      else if (c == 4) tag = "R5";
      else if (c == 3) tag = "R4";
      else             tag = "R3";
      check(tag, 32'(mem_addr), 32'(e_ma));
      check({tag, "/R8 err"}, 32'(cfg_err), 32'(e_err));
      check("R9", 32'(col_cmd), 32'(e_cmd));
      if (v && c <= 4) check("R6", 32'(mem_addr[10]), 32'(ap));
   endtask

   initial begin
      #2000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [11:0] first;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1", 32'(mem_addr), 0);
      check("R1", 32'(col_cmd), 0);
      check("R1", 32'(cfg_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 32'({mem_addr, col_cmd, cfg_err}), 0);

      for (int c = 0; c < 5; c++) apply(1'b1, 3'(c), 14'h3fff, 1'b0);
      for (int c = 0; c < 5; c++) apply(1'b1, 3'(c), 14'h2000, 1'b1);
      apply(1'b1, 3'd4, 14'h3ff8, 1'b1);
      apply(1'b1, 3'd7, 14'h1555, 1'b0);
      apply(1'b0, 3'd0, 14'h0000, 1'b0);
      apply(1'b1, 3'd5, 14'h0aaa, 1'b1);
      apply(1'b1, 3'd6, 14'h0fff, 1'b0);
      apply(1'b1, 3'd2, 14'h0123, 1'b0);

      // R2: byte-offset bits must not change the bus
      apply(1'b1, 3'd4, 14'h2a50, 1'b0);
      first = mem_addr;
      apply(1'b1, 3'd4, 14'h2a57, 1'b0);
      check("R2", 32'(mem_addr), 32'(first));

      for (int i = 0; i < 3000; i++)
         apply(1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
               14'($urandom), 1'($urandom));

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule